// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the entry half of processor exception handling. A request carries a cause code together with the current status word, the current program counter and the high-vector control bit. The sequencer turns the cause into a target mode and a vector address, and moves the vector to the top of the address space when the high-vector bit is set. It asks the banked register file to switch to the new mode. It then writes the old status into the saved status register and builds the new status word, with the mode field replaced and interrupts disabled. Finally it produces the link value, which is the current program counter, and the new program counter, which is the vector.

The request side is a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an entry is in progress, and the requester must hold `req_valid` and its fields steady until the request is taken. The bank switch request and the done pulse are plain control pins and have no back-pressure. The downstream logic has to accept them in the cycle they appear. The result registers keep their values until the next entry completes.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause code 0 (privileged call) enters mode 5'h13 with vector offset 0x08.
- R2: Cause code 1 (instruction trap) enters mode 5'h17 with offset 0x0C. Cause code 2 (data trap) enters mode 5'h17 with offset 0x10.
- R3: Cause code 3 (external interrupt) enters mode 5'h12 with offset 0x18.
- R4: When `hi_vec` is high at acceptance, the vector is 0xFFFF0000 plus the offset. When it is low, the vector is the offset alone.
- R5: In the cycle after acceptance, `bank_req` is high for exactly one cycle, with `bank_old_mode` equal to status bits [4:0] and `bank_new_mode` equal to the target mode. `bank_req` stays low when the two modes are equal.
- R6: On completion, `saved_status` equals the status word as it was at acceptance.
- R7: On completion, `status_out` equals the accepted status with bits [4:0] replaced by the target mode and bit 7 (interrupt disable) set. All other bits are unchanged.
- R8: On completion, `link_out` equals the PC as it was at acceptance, and `pc_out` equals the vector address.
- R9: `done` pulses for one cycle two cycles after the accepting edge. `req_ready` is low in between.
- R10: A cause code of 4 to 7 gives a one-cycle `unhandled` pulse in the cycle after acceptance. It raises no `bank_req` and no `done`, leaves all result outputs unchanged, and keeps `req_ready` high.
- R11: After reset, `req_ready` is 1, `done`, `bank_req` and `unhandled` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cause | input | 3 | Cause code |
| cur_status | input | 32 | Status word before entry |
| cur_pc | input | 32 | Program counter before entry |
| hi_vec | input | 1 | High-vector control bit |
| bank_req | output | 1 | Banked register switch request |
| bank_old_mode | output | 5 | Mode being left |
| bank_new_mode | output | 5 | Mode being entered |
| done | output | 1 | Entry complete, result outputs updated |
| unhandled | output | 1 | Unknown cause code seen |
| pc_out | output | 32 | New program counter (vector) |
| status_out | output | 32 | New status word |
| saved_status | output | 32 | Saved status register value |
| link_out | output | 32 | Link register value |

## Verification
A wrong captured cause or a wrong mode table shows up at `bank_new_mode` one cycle after acceptance, and then in `pc_out` and `status_out` when `done` rises one cycle later. A sequencing state that is stuck or skipped shows up at once as a missing `bank_req` or a `req_ready` that is wrong in the cycle after acceptance, and as a `done` pulse that is early, late or missing. Corrupted capture registers appear in `saved_status` and `link_out` when the entry completes. An unknown cause that leaks into the result path shows up as changed outputs or a spurious `done`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN     = 32;
  localparam int MODE_W   = 5;
  localparam int CAUSE_W  = 3;
  localparam int IDIS_BIT = 7;

  localparam logic [CAUSE_W-1:0] CAUSE_PCALL = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ITRAP = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_DTRAP = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = 3'd3;

  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;

  localparam logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BANK   = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic              known;
    logic [MODE_W-1:0] mode;
    logic [XLEN-1:0]   vector;
  } vec_sel_t;
endpackage

// File: rtl/exc_vec_decode.sv
module exc_vec_decode
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic               hi_vec,
  output vec_sel_t           sel
);
  logic [7:0] offset;

  always_comb begin
    sel.known = 1'b1;
    sel.mode  = MODE_PRIV;
    offset    = 8'h00;
    unique case (cause)
      CAUSE_PCALL: begin sel.mode = MODE_PRIV; offset = 8'h08; end
      CAUSE_ITRAP: begin sel.mode = MODE_TRAP; offset = 8'h0C; end
      CAUSE_DTRAP: begin sel.mode = MODE_TRAP; offset = 8'h10; end
      CAUSE_IRQ:   begin sel.mode = MODE_INTR; offset = 8'h18; end
      default:     begin sel.known = 1'b0; end
    endcase
    sel.vector = {{(XLEN-8){1'b0}}, offset};
    if (hi_vec) sel.vector = HIVEC_BASE + sel.vector;
  end
endmodule

// File: rtl/exc_status_build.sv
module exc_status_build
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0]   old_status,
  input  logic [MODE_W-1:0] new_mode,
  output logic [XLEN-1:0]   new_status
);
  localparam logic [XLEN-1:0] MODE_MASK = {{(XLEN-MODE_W){1'b0}}, {MODE_W{1'b1}}};

  always_comb begin
    new_status = (old_status & ~MODE_MASK) | {{(XLEN-MODE_W){1'b0}}, new_mode};
    new_status[IDIS_BIT] = 1'b1;
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic known,
  output logic idle,
  output logic bank_phase,
  output logic commit_phase,
  output logic bad_cause
);
  seq_state_t state, state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (accept && known) state_d = ST_BANK;
      ST_BANK:   state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bad_cause <= 1'b0;
    end else begin
      state     <= state_d;
      bad_cause <= accept && !known;
    end
  end

  assign idle         = (state == ST_IDLE);
  assign bank_phase   = (state == ST_BANK);
  assign commit_phase = (state == ST_COMMIT);

  // R9
  commit_follows_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_phase |-> $past(bank_phase));
  // R9
  known_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && known) |=> bank_phase);
  // R10
  bad_cause_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !known) |=> idle);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [XLEN-1:0]    cur_status,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               hi_vec,
  output logic               bank_req,
  output logic [MODE_W-1:0]  bank_old_mode,
  output logic [MODE_W-1:0]  bank_new_mode,
  output logic               done,
  output logic               unhandled,
  output logic [XLEN-1:0]    pc_out,
  output logic [XLEN-1:0]    status_out,
  output logic [XLEN-1:0]    saved_status,
  output logic [XLEN-1:0]    link_out
);
  vec_sel_t          dec;
  logic              accept, idle, bank_phase, commit_phase;
  logic [XLEN-1:0]   cap_status, cap_pc, cap_vec, built_status;
  logic [MODE_W-1:0] cap_mode;

  exc_vec_decode u_dec (
    .cause  (req_cause),
    .hi_vec (hi_vec),
    .sel    (dec)
  );

  assign accept = req_valid && idle;

  exc_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .known        (dec.known),
    .idle         (idle),
    .bank_phase   (bank_phase),
    .commit_phase (commit_phase),
    .bad_cause    (unhandled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_status <= '0;
      cap_pc     <= '0;
      cap_vec    <= '0;
      cap_mode   <= '0;
    end else if (accept && dec.known) begin
      cap_status <= cur_status;
      cap_pc     <= cur_pc;
      cap_vec    <= dec.vector;
      cap_mode   <= dec.mode;
    end
  end

  exc_status_build u_stat (
    .old_status (cap_status),
    .new_mode   (cap_mode),
    .new_status (built_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out       <= '0;
      status_out   <= '0;
      saved_status <= '0;
      link_out     <= '0;
      done         <= 1'b0;
    end else begin
      done <= commit_phase;
      if (commit_phase) begin
        saved_status <= cap_status;
        status_out   <= built_status;
        link_out     <= cap_pc;
        pc_out       <= cap_vec;
      end
    end
  end

  assign req_ready     = idle;
  assign bank_old_mode = cap_status[MODE_W-1:0];
  assign bank_new_mode = cap_mode;
  assign bank_req      = bank_phase && (bank_old_mode != bank_new_mode);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  bank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req |=> !bank_req);
  // R9
  bank_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req |-> !req_ready);
  // R10
  unhandled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> (!bank_req && !done));
  // R7
  idis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status_out[IDIS_BIT]);
  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pc_out) && $stable(link_out) && $stable(saved_status)));
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cause = '0;
  logic [31:0] cur_status = '0;
  logic [31:0] cur_pc = '0;
  logic        hi_vec = 1'b0;
  logic        bank_req, done, unhandled;
  logic [4:0]  bank_old_mode, bank_new_mode;
  logic [31:0] pc_out, status_out, saved_status, link_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] e_pc = '0, e_st = '0, e_sv = '0, e_lk = '0;

  always #2 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] f_mode(input logic [2:0] c);
    case (c)
      3'd0: return 5'h13;
      3'd1, 3'd2: return 5'h17;
      default: return 5'h12;
    endcase
  endfunction

  function automatic logic [31:0] f_vec(input logic [2:0] c, input logic h);
    logic [31:0] o;
    case (c)
      3'd0: o = 32'h08;
      3'd1: o = 32'h0C;
      3'd2: o = 32'h10;
      default: o = 32'h18;
    endcase
    return h ? 32'hFFFF0000 + o : o;
  endfunction

  function automatic logic [31:0] f_stat(input logic [31:0] s, input logic [4:0] m);
    logic [31:0] r;
    r = {s[31:5], m};
    r[7] = 1'b1;
    return r;
  endfunction

  task automatic entry(input logic [2:0] c, input logic [31:0] s, input logic [31:0] p, input logic h);
    bit known;
    logic [4:0] m;
    known = (c < 3'd4);
    m = f_mode(c);
    @(negedge clk);
    req_valid = 1'b1; req_cause = c; cur_status = s; cur_pc = p; hi_vec = h;
    chk(req_ready === 1'b1, "R9 ready before request", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    cur_status = $urandom; cur_pc = $urandom; hi_vec = ~h;
    if (known) begin
      chk(bank_req === (s[4:0] != m), "R5 bank_req", {31'd0, bank_req}, {31'd0, s[4:0] != m});
      chk(bank_old_mode === s[4:0], "R5 old mode", {27'd0, bank_old_mode}, {27'd0, s[4:0]});
      chk(bank_new_mode === m, "R1 R2 R3 new mode", {27'd0, bank_new_mode}, {27'd0, m});
      chk(req_ready === 1'b0, "R9 busy", {31'd0, req_ready}, 32'd0);
      chk(done === 1'b0, "R9 early done", {31'd0, done}, 32'd0);
      @(negedge clk);
      chk(bank_req === 1'b0, "R5 bank one cycle", {31'd0, bank_req}, 32'd0);
      chk(done === 1'b0, "R9 early done", {31'd0, done}, 32'd0);
      @(negedge clk);
      e_pc = f_vec(c, h); e_st = f_stat(s, m); e_sv = s; e_lk = p;
      chk(done === 1'b1, "R9 done", {31'd0, done}, 32'd1);
      chk(pc_out === e_pc, "R4 R8 pc", pc_out, e_pc);
      chk(status_out === e_st, "R7 status", status_out, e_st);
      chk(saved_status === e_sv, "R6 saved", saved_status, e_sv);
      chk(link_out === e_lk, "R8 link", link_out, e_lk);
      @(negedge clk);
      chk(done === 1'b0, "R9 done width", {31'd0, done}, 32'd0);
    end else begin
      chk(unhandled === 1'b1, "R10 unhandled", {31'd0, unhandled}, 32'd1);
      chk(bank_req === 1'b0, "R10 no bank", {31'd0, bank_req}, 32'd0);
      chk(req_ready === 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      chk(unhandled === 1'b0, "R10 pulse width", {31'd0, unhandled}, 32'd0);
      chk(done === 1'b0, "R10 no done", {31'd0, done}, 32'd0);
      chk(pc_out === e_pc, "R10 pc held", pc_out, e_pc);
      chk(status_out === e_st, "R10 status held", status_out, e_st);
      chk(link_out === e_lk, "R10 link held", link_out, e_lk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready", {31'd0, req_ready}, 32'd1);
    chk(done === 1'b0 && bank_req === 1'b0 && unhandled === 1'b0, "R11 pulses", {29'd0, done, bank_req, unhandled}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc_out === '0 && status_out === '0 && saved_status === '0 && link_out === '0,
        "R11 results", pc_out | status_out | saved_status | link_out, 32'd0);
    // directed corners
    entry(3'd0, 32'h0000_0010, 32'h1234_5678, 1'b0);   // R1
    entry(3'd1, 32'h8000_0013, 32'h0000_4000, 1'b1);   // R2, R4
    entry(3'd2, 32'hFFFF_FF7F, 32'hDEAD_BEEC, 1'b0);   // R2, R7
    entry(3'd3, 32'h0000_0012, 32'h0000_0100, 1'b1);   // R3, R5 same mode
    entry(3'd5, 32'h0, 32'hFFFF_FFFF, 1'b1);           // R10
    entry(3'd1, 32'h0000_0017, 32'h0000_0004, 1'b0);   // R5 same mode
    entry(3'd7, 32'h1, 32'h2, 1'b0);                   // R10
    for (int i = 0; i < 400; i++) begin
      logic [31:0] s;
      logic [2:0]  c;
      c = 3'($urandom);
      s = $urandom;
      if ((i % 5) == 0) s[4:0] = f_mode(c);
      entry(c, s, $urandom, 1'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule